// File: doc/BRIEF.md
# Counter-Mode Block Cipher Sequencer

This block drives an external block-cipher engine in counter mode over a region of a shared byte-wide memory. A host configures it through a narrow command port: a 2-bit command code, a 16-bit address and an 8-bit data byte. Through that port the host loads a region address and a byte length. It also loads a 128-bit counter, two 128-bit keys and a key-select bit. All registers are reached one byte at a time through a 64-byte window.

Once started, the block works through the region in 16-byte blocks. For each block it fetches the 16 bytes one per cycle and hands the block to the cipher engine, together with the counter and the selected key. It waits for the engine to report completion, then writes the 16 result bytes back to the same addresses. The counter steps by one after every block. The host can poll the phase register at any time. Configuration writes are refused until the block is idle again.

Top module: `ctr_cipher_seq`

## Requirements
- R1: After reset the phase is idle (0), `rsp_data` is 0, and `mem_rd`, `mem_wr` and `cph_start` are low.
- R2: Command code 1 is a read and code 2 is a write. Only addresses 0xFF00 to 0xFF3F are decoded; other codes and addresses change no register. A read updates `rsp_data` on the next clock edge. Unmapped offsets inside the window read as 0, and `rsp_data` holds its value when no read is issued.
- R3: Writes take effect only while the phase is idle. A write during a run leaves every register unchanged and does not alter the result of the run.
- R4: Register map, little-endian within each register. Offset 0x00 holds phase/start and reads back the phase zero-extended: 0 idle, 1 read, 2 operate, 3 write. Offset 0x01 holds the key select (bit 0). Offsets 0x02–0x03 hold the address and 0x04–0x05 the length. Offsets 0x10–0x1F hold the counter, 0x20–0x2F key 0 and 0x30–0x3F key 1.
- R5: Writing data 1 to offset 0x00 while idle clears the byte count and enters the read phase on the next edge. Any other data value starts nothing.
- R6: The read phase issues 16 reads, one per cycle, at address + count + i for i = 0..15. It samples `mem_rdata` in the cycle after each `mem_rd`. Byte i is placed in bits 8i+7:8i of the block.
- R7: The operate phase raises `cph_start` for exactly one cycle. It presents the counter, key 0 (select 0) or key 1 (select 1), and the block. It stays in this phase until `cph_done`, and captures `cph_result` in that cycle.
- R8: The write phase issues 16 writes, one per cycle, at the same addresses as the reads. Byte i of the result goes to address + count + i.
- R9: After the last write of a block, if count + 16 < length the count advances by 16 and the block re-enters the read phase. Otherwise it returns to idle. A length of 16 or less, zero included, therefore processes exactly one block.
- R10: The counter register increments by 1 after each block; the new value is readable once the block is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_op | input | 2 | Command code: 1 read, 2 write, others no-op |
| cmd_addr | input | 16 | Command address |
| cmd_wdata | input | 8 | Command write data |
| rsp_data | output | 8 | Registered read response |
| mem_addr | output | 16 | Shared memory byte address |
| mem_rd | output | 1 | Memory read strobe, data valid next cycle |
| mem_wr | output | 1 | Memory write strobe |
| mem_wdata | output | 8 | Memory write data |
| mem_rdata | input | 8 | Memory read data |
| cph_start | output | 1 | One-cycle request to the cipher engine |
| cph_ctr | output | 128 | Counter value for the cipher |
| cph_key | output | 128 | Selected key for the cipher |
| cph_data | output | 128 | Block data for the cipher |
| cph_done | input | 1 | Cipher result valid |
| cph_result | input | 128 | Cipher result |

## Verification
The hardest situation to reach is a configuration write arriving mid-run. This means a key or length byte sent while the sequencer is fetching a block, which must leave both the register and the data written back untouched. The stimulus gets there by issuing the write in the cycle right after the start command, when the phase is known to be read. It then compares the memory image against a model that uses the original key. The loop-termination boundary is reached by choosing lengths of 0, 32 and 40. This pins down where the strict comparison stops the run, and a guard byte just past the last block confirms nothing extra is written.

// File: rtl/ctr_cipher_seq_pkg.sv
package ctr_cipher_seq_pkg;

    localparam int BYTE_W = 8;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_READ  = 2'd1,
        PH_OPER  = 2'd2,
        PH_WRITE = 2'd3
    } phase_e;

    localparam logic [1:0] CMD_RD = 2'd1;
    localparam logic [1:0] CMD_WR = 2'd2;

    // register offsets inside the command window
    localparam int OFS_CTRL = 'h00;
    localparam int OFS_KSEL = 'h01;
    localparam int OFS_ADDR = 'h02;
    localparam int OFS_LEN  = 'h04;
    localparam int OFS_CTR  = 'h10;
    localparam int OFS_KEY0 = 'h20;
    localparam int OFS_KEY1 = 'h30;

endpackage

// File: rtl/ctr_cipher_seq_regs.sv
module ctr_cipher_seq_regs
    import ctr_cipher_seq_pkg::*;
#(
    parameter int          AW       = 16,
    parameter int          BW       = 128,
    parameter int          WIN_BITS = 6,
    parameter logic [AW-1:0] WIN_BASE = 16'hFF00
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        cmd_op,
    input  logic [AW-1:0]     cmd_addr,
    input  logic [BYTE_W-1:0] cmd_wdata,
    input  phase_e            phase,
    input  logic              ctr_inc,
    output logic [BYTE_W-1:0] rsp_data,
    output logic              start,
    output logic [AW-1:0]     base,
    output logic [AW-1:0]     len,
    output logic [BW-1:0]     ctr,
    output logic [BW-1:0]     key0,
    output logic [BW-1:0]     key1,
    output logic              ksel
);

    localparam int AB = AW / BYTE_W;
    localparam int NB = BW / BYTE_W;

    typedef struct packed {
        logic [AW-1:0]     base;
        logic [AW-1:0]     len;
        logic [BW-1:0]     ctr;
        logic [BW-1:0]     key0;
        logic [BW-1:0]     key1;
        logic              ksel;
        logic [BYTE_W-1:0] rsp;
    } regs_t;

    regs_t rf_d, rf_q;

    logic                in_win;
    logic [WIN_BITS-1:0] off_w;
    logic                wr_ok;
    logic [BYTE_W-1:0]   rd_byte;

    assign in_win = (cmd_addr[AW-1:WIN_BITS] == WIN_BASE[AW-1:WIN_BITS]);
    assign off_w  = cmd_addr[WIN_BITS-1:0];

    always_comb begin
        rf_d    = rf_q;
        rd_byte = '0;
        wr_ok   = (cmd_op == CMD_WR) && in_win && (phase == PH_IDLE);
        start   = wr_ok && (int'(off_w) == OFS_CTRL) && (cmd_wdata == 8'd1);

        if (wr_ok && int'(off_w) == OFS_KSEL) begin
            rf_d.ksel = cmd_wdata[0];
        end

        for (int i = 0; i < AB; i++) begin
            if (int'(off_w) == OFS_ADDR + i) begin
                rd_byte = rf_q.base[BYTE_W*i +: BYTE_W];
                if (wr_ok) rf_d.base[BYTE_W*i +: BYTE_W] = cmd_wdata;
            end
            if (int'(off_w) == OFS_LEN + i) begin
                rd_byte = rf_q.len[BYTE_W*i +: BYTE_W];
                if (wr_ok) rf_d.len[BYTE_W*i +: BYTE_W] = cmd_wdata;
            end
        end

        for (int i = 0; i < NB; i++) begin
            if (int'(off_w) == OFS_CTR + i) begin
                rd_byte = rf_q.ctr[BYTE_W*i +: BYTE_W];
                if (wr_ok) rf_d.ctr[BYTE_W*i +: BYTE_W] = cmd_wdata;
            end
            if (int'(off_w) == OFS_KEY0 + i) begin
                rd_byte = rf_q.key0[BYTE_W*i +: BYTE_W];
                if (wr_ok) rf_d.key0[BYTE_W*i +: BYTE_W] = cmd_wdata;
            end
            if (int'(off_w) == OFS_KEY1 + i) begin
                rd_byte = rf_q.key1[BYTE_W*i +: BYTE_W];
                if (wr_ok) rf_d.key1[BYTE_W*i +: BYTE_W] = cmd_wdata;
            end
        end

        if (int'(off_w) == OFS_CTRL) rd_byte = BYTE_W'(phase);
        if (int'(off_w) == OFS_KSEL) rd_byte = BYTE_W'(rf_q.ksel);
        if (!in_win)                 rd_byte = '0;

        // counter steps once per finished block; writes are locked out then
        if (ctr_inc) rf_d.ctr = rf_q.ctr + 1'b1;

        if (cmd_op == CMD_RD) rf_d.rsp = rd_byte;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rf_q <= '0;
        else        rf_q <= rf_d;
    end

    assign rsp_data = rf_q.rsp;
    assign base     = rf_q.base;
    assign len      = rf_q.len;
    assign ctr      = rf_q.ctr;
    assign key0     = rf_q.key0;
    assign key1     = rf_q.key1;
    assign ksel     = rf_q.ksel;

endmodule

// File: rtl/ctr_cipher_seq_fsm.sv
module ctr_cipher_seq_fsm
    import ctr_cipher_seq_pkg::*;
#(
    parameter int AW = 16,
    parameter int BW = 128
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [AW-1:0]     base,
    input  logic [AW-1:0]     len,
    input  logic [BYTE_W-1:0] mem_rdata,
    input  logic              cph_done,
    input  logic [BW-1:0]     cph_result,
    output phase_e            phase,
    output logic [AW-1:0]     mem_addr,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic [BYTE_W-1:0] mem_wdata,
    output logic              cph_start,
    output logic [BW-1:0]     cph_data,
    output logic              ctr_inc
);

    localparam int            NB   = BW / BYTE_W;
    localparam int            IW   = $clog2(NB) + 1;
    localparam logic [AW:0]   STEP = NB;

    typedef struct packed {
        phase_e        ph;
        logic [AW-1:0] cnt;
        logic [IW-1:0] idx;
        logic          sent;
        logic [BW-1:0] blk;
    } seq_t;

    seq_t sq_d, sq_q;

    always_comb begin
        sq_d      = sq_q;
        mem_rd    = 1'b0;
        mem_wr    = 1'b0;
        cph_start = 1'b0;
        ctr_inc   = 1'b0;
        mem_addr  = base + sq_q.cnt + AW'(sq_q.idx);
        mem_wdata = sq_q.blk[BYTE_W*int'(sq_q.idx[IW-2:0]) +: BYTE_W];

        unique case (sq_q.ph)
            PH_IDLE: begin
                if (start) begin
                    sq_d.cnt = '0;
                    sq_d.idx = '0;
                    sq_d.ph  = PH_READ;
                end
            end
            PH_READ: begin
                // data of the read issued last cycle arrives now
                if (sq_q.idx != '0) begin
                    sq_d.blk[BYTE_W*(int'(sq_q.idx) - 1) +: BYTE_W] = mem_rdata;
                end
                if (int'(sq_q.idx) < NB) begin
                    mem_rd   = 1'b1;
                    sq_d.idx = sq_q.idx + 1'b1;
                end else begin
                    sq_d.idx  = '0;
                    sq_d.sent = 1'b0;
                    sq_d.ph   = PH_OPER;
                end
            end
            PH_OPER: begin
                if (!sq_q.sent) begin
                    cph_start = 1'b1;
                    sq_d.sent = 1'b1;
                end else if (cph_done) begin
                    sq_d.blk = cph_result;
                    sq_d.idx = '0;
                    sq_d.ph  = PH_WRITE;
                end
            end
            PH_WRITE: begin
                mem_wr = 1'b1;
                if (int'(sq_q.idx) == NB - 1) begin
                    ctr_inc  = 1'b1;
                    sq_d.idx = '0;
                    if (({1'b0, sq_q.cnt} + STEP) < {1'b0, len}) begin
                        sq_d.cnt = sq_q.cnt + STEP[AW-1:0];
                        sq_d.ph  = PH_READ;
                    end else begin
                        sq_d.ph  = PH_IDLE;
                    end
                end else begin
                    sq_d.idx = sq_q.idx + 1'b1;
                end
            end
            default: sq_d.ph = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sq_q <= '0;
        else        sq_q <= sq_d;
    end

    assign phase    = sq_q.ph;
    assign cph_data = sq_q.blk;

endmodule

// File: rtl/ctr_cipher_seq.sv
module ctr_cipher_seq
    import ctr_cipher_seq_pkg::*;
#(
    parameter int            AW       = 16,
    parameter int            BW       = 128,
    parameter int            WIN_BITS = 6,
    parameter logic [AW-1:0] WIN_BASE = 16'hFF00
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [1:0]    cmd_op,
    input  logic [AW-1:0] cmd_addr,
    input  logic [7:0]    cmd_wdata,
    output logic [7:0]    rsp_data,
    output logic [AW-1:0] mem_addr,
    output logic          mem_rd,
    output logic          mem_wr,
    output logic [7:0]    mem_wdata,
    input  logic [7:0]    mem_rdata,
    output logic          cph_start,
    output logic [BW-1:0] cph_ctr,
    output logic [BW-1:0] cph_key,
    output logic [BW-1:0] cph_data,
    input  logic          cph_done,
    input  logic [BW-1:0] cph_result
);

    phase_e        phase;
    logic          start;
    logic          ctr_inc;
    logic [AW-1:0] cfg_base;
    logic [AW-1:0] cfg_len;
    logic [BW-1:0] cfg_ctr;
    logic [BW-1:0] cfg_key0;
    logic [BW-1:0] cfg_key1;
    logic          cfg_ksel;

    ctr_cipher_seq_regs #(
        .AW       (AW),
        .BW       (BW),
        .WIN_BITS (WIN_BITS),
        .WIN_BASE (WIN_BASE)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_op    (cmd_op),
        .cmd_addr  (cmd_addr),
        .cmd_wdata (cmd_wdata),
        .phase     (phase),
        .ctr_inc   (ctr_inc),
        .rsp_data  (rsp_data),
        .start     (start),
        .base      (cfg_base),
        .len       (cfg_len),
        .ctr       (cfg_ctr),
        .key0      (cfg_key0),
        .key1      (cfg_key1),
        .ksel      (cfg_ksel)
    );

    ctr_cipher_seq_fsm #(
        .AW (AW),
        .BW (BW)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .base       (cfg_base),
        .len        (cfg_len),
        .mem_rdata  (mem_rdata),
        .cph_done   (cph_done),
        .cph_result (cph_result),
        .phase      (phase),
        .mem_addr   (mem_addr),
        .mem_rd     (mem_rd),
        .mem_wr     (mem_wr),
        .mem_wdata  (mem_wdata),
        .cph_start  (cph_start),
        .cph_data   (cph_data),
        .ctr_inc    (ctr_inc)
    );

    assign cph_ctr = cfg_ctr;
    assign cph_key = cfg_ksel ? cfg_key1 : cfg_key0;

endmodule

// File: rtl/ctr_cipher_seq_chk.sv
module ctr_cipher_seq_chk
    import ctr_cipher_seq_pkg::*;
#(
    parameter int            AW       = 16,
    parameter int            BW       = 128,
    parameter logic [AW-1:0] WIN_BASE = 16'hFF00
) (
    input logic          clk,
    input logic          rst_n,
    input logic [1:0]    cmd_op,
    input logic [AW-1:0] cmd_addr,
    input logic [7:0]    cmd_wdata,
    input logic [7:0]    rsp_data,
    input logic          mem_rd,
    input logic          mem_wr,
    input logic          cph_start,
    input phase_e        phase,
    input logic [AW-1:0] cfg_base,
    input logic [AW-1:0] cfg_len,
    input logic [BW-1:0] cfg_ctr,
    input logic [BW-1:0] cfg_key0,
    input logic [BW-1:0] cfg_key1,
    input logic          cfg_ksel
);

    p_rsp_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_op != CMD_RD) |=> $stable(rsp_data));

    p_busy_lock_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (phase != PH_IDLE) |=> ($stable(cfg_base) && $stable(cfg_len) &&
                                $stable(cfg_key0) && $stable(cfg_key1) &&
                                $stable(cfg_ksel)));

    p_start_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_IDLE && cmd_op == CMD_WR && cmd_addr == WIN_BASE &&
         cmd_wdata == 8'd1) |=> (phase == PH_READ));

    p_rd_in_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |-> (phase == PH_READ));

    p_start_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cph_start |-> (phase == PH_OPER) ##1 !cph_start);

    p_wr_in_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr |-> (phase == PH_WRITE));

    p_ctr_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (phase != PH_IDLE) |=> (cfg_ctr == $past(cfg_ctr) ||
                                cfg_ctr == $past(cfg_ctr) + 1'b1));

endmodule

bind ctr_cipher_seq ctr_cipher_seq_chk #(
    .AW       (AW),
    .BW       (BW),
    .WIN_BASE (WIN_BASE)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_op    (cmd_op),
    .cmd_addr  (cmd_addr),
    .cmd_wdata (cmd_wdata),
    .rsp_data  (rsp_data),
    .mem_rd    (mem_rd),
    .mem_wr    (mem_wr),
    .cph_start (cph_start),
    .phase     (phase),
    .cfg_base  (cfg_base),
    .cfg_len   (cfg_len),
    .cfg_ctr   (cfg_ctr),
    .cfg_key0  (cfg_key0),
    .cfg_key1  (cfg_key1),
    .cfg_ksel  (cfg_ksel)
);

// File: tb/ctr_cipher_seq_tb_top.sv
module ctr_cipher_seq_tb_top;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [1:0]   cmd_op = 2'd0;
    logic [15:0]  cmd_addr = 16'd0;
    logic [7:0]   cmd_wdata = 8'd0;
    logic [7:0]   rsp_data;
    logic [15:0]  mem_addr;
    logic         mem_rd, mem_wr;
    logic [7:0]   mem_wdata;
    logic [7:0]   mem_rdata = 8'd0;
    logic         cph_start;
    logic [127:0] cph_ctr, cph_key, cph_data;
    logic         cph_done = 1'b0;
    logic [127:0] cph_result = '0;

    int checks = 0;
    int errors = 0;
    int rd_cnt = 0;
    int wr_cnt = 0;
    int st_cnt = 0;

    logic [7:0]   mem     [0:255];
    logic [7:0]   exp_mem [0:255];
    logic [127:0] stub_val = '0;
    int           stub_cnt = 0;

    always #4 clk = ~clk;

    ctr_cipher_seq dut_i (
        .clk(clk), .rst_n(rst_n), .cmd_op(cmd_op), .cmd_addr(cmd_addr),
        .cmd_wdata(cmd_wdata), .rsp_data(rsp_data), .mem_addr(mem_addr),
        .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .cph_start(cph_start), .cph_ctr(cph_ctr),
        .cph_key(cph_key), .cph_data(cph_data), .cph_done(cph_done),
        .cph_result(cph_result)
    );

    // byte memory with one-cycle read latency, plus strobe counters
    always @(posedge clk) begin
        if (mem_wr) mem[mem_addr[7:0]] <= mem_wdata;
        if (mem_rd) mem_rdata <= mem[mem_addr[7:0]];
        if (mem_rd) rd_cnt <= rd_cnt + 1;
        if (mem_wr) wr_cnt <= wr_cnt + 1;
        if (cph_start) st_cnt <= st_cnt + 1;
    end

    // cipher stub: result = data ^ key ^ counter, done two cycles after start
    always @(posedge clk) begin
        cph_done <= 1'b0;
        if (cph_start) begin
            stub_val <= cph_data ^ cph_key ^ cph_ctr;
            stub_cnt <= 2;
        end else if (stub_cnt != 0) begin
            stub_cnt <= stub_cnt - 1;
            if (stub_cnt == 1) begin
                cph_done   <= 1'b1;
                cph_result <= stub_val;
            end
        end
    end

    task automatic check(input bit ok, input string tag,
                         input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic host_wr(input logic [15:0] a, input logic [7:0] d);
        cmd_op = 2'd2; cmd_addr = a; cmd_wdata = d;
        @(negedge clk);
        cmd_op = 2'd0;
    endtask

    task automatic host_rd(input logic [15:0] a, output logic [7:0] d);
        cmd_op = 2'd1; cmd_addr = a;
        @(negedge clk);
        cmd_op = 2'd0;
        d = rsp_data;
    endtask

    task automatic wr_n(input logic [15:0] a, input int n, input logic [127:0] v);
        for (int i = 0; i < n; i++) host_wr(a + 16'(i), v[8*i +: 8]);
    endtask

    task automatic rd_n(input logic [15:0] a, input int n, output logic [127:0] v);
        logic [7:0] b;
        v = '0;
        for (int i = 0; i < n; i++) begin
            host_rd(a + 16'(i), b);
            v[8*i +: 8] = b;
        end
    endtask

    task automatic configure(input logic [15:0] base, input logic [15:0] len,
                             input logic [127:0] ctr, input logic [127:0] k0,
                             input logic [127:0] k1, input logic ks);
        wr_n(16'hFF02, 2, {112'd0, base});
        wr_n(16'hFF04, 2, {112'd0, len});
        wr_n(16'hFF10, 16, ctr);
        wr_n(16'hFF20, 16, k0);
        wr_n(16'hFF30, 16, k1);
        host_wr(16'hFF01, {7'd0, ks});
    endtask

    // expected memory image and block count from the requirements
    task automatic model(input logic [15:0] base, input logic [15:0] len,
                         input logic [127:0] ctr, input logic [127:0] key,
                         output int nblk);
        logic [127:0] pt, ct;
        int cnt = 0;
        nblk = 0;
        forever begin
            for (int i = 0; i < 16; i++) pt[8*i +: 8] = exp_mem[8'(base + 16'(cnt + i))];
            ct = pt ^ key ^ (ctr + 128'(nblk));
            for (int i = 0; i < 16; i++) exp_mem[8'(base + 16'(cnt + i))] = ct[8*i +: 8];
            nblk++;
            if (cnt + 16 < int'(len)) cnt += 16;
            else break;
        end
    endtask

    task automatic wait_idle(input string tag);
        logic [7:0] s;
        bit done = 0;
        for (int t = 0; t < 3000; t++) begin
            host_rd(16'hFF00, s);
            if (s == 8'd0) begin done = 1; break; end
        end
        check(done, tag, 128'(s), 128'd0);
    endtask

    task automatic cmp_mem(input string tag);
        int bad = -1;
        for (int i = 0; i < 256; i++) if (mem[i] !== exp_mem[i] && bad < 0) bad = i;
        if (bad < 0) check(1'b1, tag, 0, 0);
        else check(1'b0, $sformatf("%s byte %0d", tag, bad), 128'(mem[bad]), 128'(exp_mem[bad]));
    endtask

    // full run of one operation with counts and counter readback
    task automatic run_op(input logic [15:0] base, input logic [15:0] len,
                          input logic [127:0] ctr, input logic [127:0] k0,
                          input logic [127:0] k1, input logic ks, input string tag);
        int nblk, r0, w0, s0;
        logic [127:0] v;
        logic [7:0] st;
        configure(base, len, ctr, k0, k1, ks);
        model(base, len, ctr, ks ? k1 : k0, nblk);
        r0 = rd_cnt; w0 = wr_cnt; s0 = st_cnt;
        host_wr(16'hFF00, 8'd1);
        host_rd(16'hFF00, st);
        check(st == 8'd1, {tag, " R5 read phase after start"}, 128'(st), 128'd1);
        wait_idle({tag, " R9 returns idle"});
        cmp_mem({tag, " R6 R7 R8 memory image"});
        check(rd_cnt - r0 == 16 * nblk, {tag, " R6 read strobes"}, 128'(rd_cnt - r0), 128'(16 * nblk));
        check(wr_cnt - w0 == 16 * nblk, {tag, " R8 write strobes"}, 128'(wr_cnt - w0), 128'(16 * nblk));
        check(st_cnt - s0 == nblk, {tag, " R9 block count"}, 128'(st_cnt - s0), 128'(nblk));
        rd_n(16'hFF10, 16, v);
        check(v == ctr + 128'(nblk), {tag, " R10 counter advance"}, v, ctr + 128'(nblk));
    endtask

    task automatic t_reset();
        logic [7:0] s;
        check(rsp_data == 8'd0, "R1 rsp_data", 128'(rsp_data), 0);
        check(!mem_rd && !mem_wr && !cph_start, "R1 strobes low",
              128'({mem_rd, mem_wr, cph_start}), 0);
        host_rd(16'hFF00, s);
        check(s == 8'd0, "R1 idle phase", 128'(s), 0);
    endtask

    task automatic t_regmap();
        logic [7:0] b;
        logic [127:0] v;
        configure(16'h1234, 16'hA55A, 128'h0f0e0d0c0b0a09080706050403020100,
                  {16{8'h3C}} ^ 128'h1, 128'hdeadbeef_00112233_44556677_8899aabb, 1'b0);
        host_rd(16'hFF02, b); check(b == 8'h34, "R4 address low byte", 128'(b), 128'h34);
        host_rd(16'hFF03, b); check(b == 8'h12, "R4 address high byte", 128'(b), 128'h12);
        rd_n(16'hFF04, 2, v); check(v == 128'hA55A, "R4 length", v, 128'hA55A);
        host_rd(16'hFF1F, b); check(b == 8'h0f, "R4 counter top byte", 128'(b), 128'h0f);
        host_rd(16'hFF20, b); check(b == 8'h3D, "R4 key0 low byte", 128'(b), 128'h3D);
        rd_n(16'hFF30, 16, v);
        check(v == 128'hdeadbeef_00112233_44556677_8899aabb, "R4 key1", v,
              128'hdeadbeef_00112233_44556677_8899aabb);
        host_wr(16'hFF01, 8'hFE); host_rd(16'hFF01, b);
        check(b == 8'd0, "R4 key select bit0 only", 128'(b), 0);
        host_wr(16'hFF01, 8'h03); host_rd(16'hFF01, b);
        check(b == 8'd1, "R4 key select set", 128'(b), 1);
        host_rd(16'hFF08, b); check(b == 8'd0, "R2 unmapped offset reads 0", 128'(b), 0);
        host_wr(16'hFE02, 8'h55); host_rd(16'hFF02, b);
        check(b == 8'h34, "R2 out-of-window write ignored", 128'(b), 128'h34);
        cmd_op = 2'd3; cmd_addr = 16'hFF02; cmd_wdata = 8'h77;
        @(negedge clk); cmd_op = 2'd0;
        host_rd(16'hFF02, b);
        check(b == 8'h34, "R2 code 3 ignored", 128'(b), 128'h34);
        @(negedge clk);
        check(rsp_data == 8'h34, "R2 response holds without read", 128'(rsp_data), 128'h34);
    endtask

    task automatic t_no_start();
        logic [7:0] s;
        int r0 = rd_cnt;
        host_wr(16'hFF00, 8'd2);
        repeat (5) @(negedge clk);
        host_rd(16'hFF00, s);
        check(s == 8'd0 && rd_cnt == r0, "R5 data 2 does not start", 128'(s), 0);
    endtask

    task automatic t_busy();
        int nblk;
        logic [127:0] v;
        logic [127:0] k0 = 128'h11223344_55667788_99aabbcc_ddeeff00;
        configure(16'h0060, 16'd16, 128'd500, k0, '0, 1'b0);
        model(16'h0060, 16'd16, 128'd500, k0, nblk);
        host_wr(16'hFF00, 8'd1);
        host_wr(16'hFF20, 8'hAA);      // phase is read here: must be refused
        host_wr(16'hFF04, 8'hFF);
        host_wr(16'hFF00, 8'd1);
        wait_idle("R3 busy run ends");
        rd_n(16'hFF20, 16, v); check(v == k0, "R3 key0 unchanged", v, k0);
        rd_n(16'hFF04, 2, v);  check(v == 128'd16, "R3 length unchanged", v, 128'd16);
        cmp_mem("R3 result uses original key");
    endtask

    initial begin
        for (int i = 0; i < 256; i++) begin
            mem[i] = 8'(i * 7 + 3);
            exp_mem[i] = 8'(i * 7 + 3);
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_regmap();
        t_no_start();
        run_op(16'h0020, 16'd16, 128'h0123, 128'hCAFE_F00D, 128'h5, 1'b0, "single key0");
        t_busy();
        run_op(16'h0080, 16'd40, 128'hFFFF_FFFF_FFFF_FFFF, 128'h7, 128'h9876_5432_1000, 1'b1, "three blocks key1");
        run_op(16'h00C0, 16'd0, 128'd77, 128'hAB, 128'hCD, 1'b0, "zero length");
        run_op(16'h0000, 16'd32, 128'd3, 128'h1F1F, 128'h2E2E, 1'b1, "two blocks boundary");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(8 * 150000);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule